// File: doc/BRIEF.md
# Cipher Key Slot Cache with Use-Count Expiry

This block holds a small set of 128-bit cipher keys in numbered slots and hands one of them, together with a per-frame cipher context, to a downstream cipher engine. Software or a key manager writes a key into a slot once. After that, switching from one protocol's frame to another takes one context load: a slot number plus the nonce, the direction, the associated-data length and the payload length. The key itself is never reloaded. The selected slot's key is presented to the cipher straight from the slot storage, and a one-cycle start pulse tells the cipher that a fresh context is in place.

Each slot counts the frames completed with its key. A slot whose expiry is enabled stops being usable once it has served a fixed number of frames, 255 by default. At that point the slot is invalidated and its renegotiation request is raised. A context still pointing at that slot is flagged as bad, and loads that name the slot are refused with an error pulse. Other slots keep working. Writing a new key into the slot restores it. Keys that are refreshed by other means can be written with expiry disabled, and their counters then saturate without effect.

Top module: `keyslot_cache`

## Requirements
- R1: After reset every slot is invalid, all renegotiation requests are 0, cph_start, ld_err and cph_ctx_bad are 0, and all context outputs, including the presented key, are 0.
- R2: A key write (kw_en) stores kw_key and kw_expire_en in slot kw_id. From the next cycle the slot is valid, its frame count is zero and its renegotiation request is 0.
- R3: A load (ld_valid) that names a valid slot sets cph_start for exactly the following cycle. From that cycle cph_nonce, cph_dir (0 = transmit/encrypt, 1 = receive/decrypt), cph_aad_len and cph_pay_len hold the loaded values until the next accepted load. cph_key shows the current key of the loaded slot.
- R4: A load that names an invalid slot sets ld_err for the following cycle, does not set cph_start, and leaves every context output unchanged.
- R5: A frame_done pulse, while a context is held and its slot is valid, adds one to the frame count of the slot named by the last accepted load. The count saturates at the limit.
- R6: With expiry enabled, the frame_done that brings a slot's count to the limit (255 by default) makes the slot invalid and sets renego_req[slot] from the next cycle. One fewer frame leaves the slot valid with no request.
- R7: While the held context's slot is invalid, cph_ctx_bad is 1. An expiry does not change the validity of any other slot, and loads of other valid slots are still accepted.
- R8: A slot written with kw_expire_en = 0 never expires, whatever its frame count.
- R9: Rewriting an expired slot clears its renegotiation request, makes it loadable again, and restarts its count, so a full limit of new frames is needed before it expires again.
- R10: frame_done has no effect when no context has been accepted since reset, or when the held context's slot is invalid.
- R11: When a key write and a counted frame_done hit the same slot in the same cycle, the write wins: the count ends at zero and no expiry occurs. A load in the same cycle as a write sees the slot's state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kw_en | input | 1 | Key write strobe |
| kw_id | input | 2 | Slot written |
| kw_key | input | 128 | Key value written |
| kw_expire_en | input | 1 | 1: slot expires after the frame limit |
| ld_valid | input | 1 | Context load strobe |
| ld_key_id | input | 2 | Slot named by the load |
| ld_nonce | input | 64 | Nonce of the new context |
| ld_dir | input | 1 | 0 encrypt (transmit), 1 decrypt (receive) |
| ld_aad_len | input | 16 | Associated-data length in bytes |
| ld_pay_len | input | 16 | Payload length in bytes, tag excluded |
| ld_err | output | 1 | Load refused (slot invalid), one cycle |
| cph_start | output | 1 | New context ready, one cycle |
| cph_key | output | 128 | Key of the held context's slot |
| cph_nonce | output | 64 | Held nonce |
| cph_dir | output | 1 | Held direction |
| cph_aad_len | output | 16 | Held associated-data length |
| cph_pay_len | output | 16 | Held payload length |
| cph_ctx_bad | output | 1 | Held context's slot is no longer valid |
| frame_done | input | 1 | Cipher finished one frame with the held context |
| renego_req | output | 4 | Per-slot request for a new key |

## Verification
Every result appears one clock edge after its stimulus. A key write makes the slot valid and drops its request at the next edge. A load produces cph_start or ld_err and the new context fields at the next edge. The final counted frame_done raises renego_req and cph_ctx_bad at the next edge. The bench drives inputs shortly after a rising edge. A behavioural model advances on the same rising edge, and every output is compared with the model at the following falling edge, so each result is checked in the cycle it is due. Directed sequences walk a slot up to one frame short of the limit and then across it, cross the limit on a slot with expiry disabled, and collide a write with a frame on the same slot.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;

   // Direction of the cipher operation as carried in the context.
   typedef enum logic {
      KS_DIR_ENCRYPT = 1'b0,
      KS_DIR_DECRYPT = 1'b1
   } ks_dir_e;

   // Default number of frames a count-limited key may serve.
   localparam int unsigned KS_DEFAULT_LIMIT = 255;

endpackage

// File: rtl/keyslot_store.sv
module keyslot_store #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned KEY_W     = 128,
   parameter int unsigned ID_W      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ID_W-1:0]      wr_id,
   input  logic [KEY_W-1:0]     wr_key,
   input  logic                 wr_exp_en,
   input  logic [NUM_SLOTS-1:0] expire_evt,
   input  logic [ID_W-1:0]      rd_a_id,
   input  logic [ID_W-1:0]      rd_b_id,
   output logic [NUM_SLOTS-1:0] valid_o,
   output logic [NUM_SLOTS-1:0] exp_en_o,
   output logic [NUM_SLOTS-1:0] renego_o,
   output logic [KEY_W-1:0]     rd_a_key,
   output logic [KEY_W-1:0]     rd_b_key
);

   logic [KEY_W-1:0] key_arr [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic             hit;
      logic [KEY_W-1:0] key_q;
      logic             valid_q;
      logic             exp_q;
      logic             reneg_q;

      assign hit = wr_en && (wr_id == ID_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            key_q   <= '0;
            valid_q <= 1'b0;
            exp_q   <= 1'b0;
            reneg_q <= 1'b0;
         end else if (hit) begin
            key_q   <= wr_key;
            valid_q <= 1'b1;
            exp_q   <= wr_exp_en;
            reneg_q <= 1'b0;
         end else if (expire_evt[g]) begin
            valid_q <= 1'b0;
            reneg_q <= 1'b1;
         end
      end

      assign key_arr[g]  = key_q;
      assign valid_o[g]  = valid_q;
      assign exp_en_o[g] = exp_q;
      assign renego_o[g] = reneg_q;
   end

   assign rd_a_key = key_arr[rd_a_id];
   assign rd_b_key = key_arr[rd_b_id];

endmodule

// File: rtl/keyslot_usage.sv
module keyslot_usage #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned USE_LIMIT = 255,
   parameter int unsigned CNT_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] clr,
   input  logic [NUM_SLOTS-1:0] inc,
   input  logic [NUM_SLOTS-1:0] exp_en,
   output logic [NUM_SLOTS-1:0] expire_evt
);

   localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(USE_LIMIT);
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(USE_LIMIT - 1);

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clr[g]) begin
            cnt_q <= '0;
         end else if (inc[g] && (cnt_q != LIMIT_C)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      // This increment is the one that reaches the limit.
      assign expire_evt[g] = inc[g] && !clr[g] && exp_en[g] && (cnt_q == LAST_C);
   end

endmodule

// File: rtl/keyslot_ctx.sv
module keyslot_ctx
   import keyslot_pkg::*;
#(
   parameter int unsigned NUM_SLOTS    = 4,
   parameter int unsigned ID_W         = 2,
   parameter int unsigned KEY_W        = 128,
   parameter int unsigned NONCE_W      = 64,
   parameter int unsigned AAD_W        = 16,
   parameter int unsigned PLEN_W       = 16,
   parameter bit          KEY_SNAPSHOT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_valid,
   input  logic [ID_W-1:0]      ld_id,
   input  logic [NONCE_W-1:0]   ld_nonce,
   input  logic                 ld_dir,
   input  logic [AAD_W-1:0]     ld_aad,
   input  logic [PLEN_W-1:0]    ld_plen,
   input  logic [NUM_SLOTS-1:0] slot_valid,
   input  logic [KEY_W-1:0]     key_of_ctx,
   input  logic [KEY_W-1:0]     key_of_ld,
   output logic [ID_W-1:0]      ctx_id,
   output logic                 ctx_live,
   output logic                 start_o,
   output logic                 err_o,
   output logic [KEY_W-1:0]     key_o,
   output logic [NONCE_W-1:0]   nonce_o,
   output logic                 dir_o,
   output logic [AAD_W-1:0]     aad_o,
   output logic [PLEN_W-1:0]    plen_o
);

   logic          accept;
   ks_dir_e       dir_q;
   logic [ID_W-1:0]    id_q;
   logic               live_q;
   logic [NONCE_W-1:0] nonce_q;
   logic [AAD_W-1:0]   aad_q;
   logic [PLEN_W-1:0]  plen_q;

   assign accept = ld_valid && slot_valid[ld_id];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         err_o   <= 1'b0;
         id_q    <= '0;
         live_q  <= 1'b0;
         nonce_q <= '0;
         dir_q   <= KS_DIR_ENCRYPT;
         aad_q   <= '0;
         plen_q  <= '0;
      end else begin
         start_o <= accept;
         err_o   <= ld_valid && !accept;
         if (accept) begin
            id_q    <= ld_id;
            live_q  <= 1'b1;
            nonce_q <= ld_nonce;
            dir_q   <= ks_dir_e'(ld_dir);
            aad_q   <= ld_aad;
            plen_q  <= ld_plen;
         end
      end
   end

   if (KEY_SNAPSHOT) begin : g_key_copy
      logic [KEY_W-1:0] key_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      key_q <= '0;
         else if (accept) key_q <= key_of_ld;
      end
      assign key_o = key_q;
   end else begin : g_key_live
      logic unused_ld_key;
      assign unused_ld_key = ^key_of_ld;
      assign key_o = key_of_ctx;
   end

   assign ctx_id   = id_q;
   assign ctx_live = live_q;
   assign nonce_o  = nonce_q;
   assign dir_o    = dir_q;
   assign aad_o    = aad_q;
   assign plen_o   = plen_q;

endmodule

// File: rtl/keyslot_cache.sv
module keyslot_cache
   import keyslot_pkg::*;
#(
   parameter int unsigned NUM_SLOTS    = 4,
   parameter int unsigned KEY_W        = 128,
   parameter int unsigned NONCE_W      = 64,
   parameter int unsigned AAD_W        = 16,
   parameter int unsigned PLEN_W       = 16,
   parameter int unsigned USE_LIMIT    = KS_DEFAULT_LIMIT,
   parameter bit          KEY_SNAPSHOT = 1'b0,
   localparam int unsigned ID_W        = $clog2(NUM_SLOTS),
   localparam int unsigned CNT_W       = $clog2(USE_LIMIT + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 kw_en,
   input  logic [ID_W-1:0]      kw_id,
   input  logic [KEY_W-1:0]     kw_key,
   input  logic                 kw_expire_en,
   input  logic                 ld_valid,
   input  logic [ID_W-1:0]      ld_key_id,
   input  logic [NONCE_W-1:0]   ld_nonce,
   input  logic                 ld_dir,
   input  logic [AAD_W-1:0]     ld_aad_len,
   input  logic [PLEN_W-1:0]    ld_pay_len,
   output logic                 ld_err,
   output logic                 cph_start,
   output logic [KEY_W-1:0]     cph_key,
   output logic [NONCE_W-1:0]   cph_nonce,
   output logic                 cph_dir,
   output logic [AAD_W-1:0]     cph_aad_len,
   output logic [PLEN_W-1:0]    cph_pay_len,
   output logic                 cph_ctx_bad,
   input  logic                 frame_done,
   output logic [NUM_SLOTS-1:0] renego_req
);

   if (NUM_SLOTS < 2 || (1 << ID_W) != NUM_SLOTS) begin : g_bad_slots
      $error("keyslot_cache: NUM_SLOTS must be a power of two, at least 2");
   end
   if (USE_LIMIT < 1) begin : g_bad_limit
      $error("keyslot_cache: USE_LIMIT must be at least 1");
   end
   if (KEY_W < 1 || NONCE_W < 1 || AAD_W < 1 || PLEN_W < 1) begin : g_bad_width
      $error("keyslot_cache: field widths must be non-zero");
   end

   logic [NUM_SLOTS-1:0] slot_valid;
   logic [NUM_SLOTS-1:0] slot_exp_en;
   logic [NUM_SLOTS-1:0] expire_evt;
   logic [NUM_SLOTS-1:0] wr_onehot;
   logic [NUM_SLOTS-1:0] inc_onehot;
   logic [ID_W-1:0]      ctx_id;
   logic                 ctx_live;
   logic [KEY_W-1:0]     key_of_ctx;
   logic [KEY_W-1:0]     key_of_ld;
   logic                 count_frame;

   assign count_frame = frame_done && ctx_live && slot_valid[ctx_id];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
      assign wr_onehot[g]  = kw_en && (kw_id == ID_W'(g));
      assign inc_onehot[g] = count_frame && (ctx_id == ID_W'(g));
   end

   keyslot_store #(
      .NUM_SLOTS (NUM_SLOTS),
      .KEY_W     (KEY_W),
      .ID_W      (ID_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (kw_en),
      .wr_id      (kw_id),
      .wr_key     (kw_key),
      .wr_exp_en  (kw_expire_en),
      .expire_evt (expire_evt),
      .rd_a_id    (ctx_id),
      .rd_b_id    (ld_key_id),
      .valid_o    (slot_valid),
      .exp_en_o   (slot_exp_en),
      .renego_o   (renego_req),
      .rd_a_key   (key_of_ctx),
      .rd_b_key   (key_of_ld)
   );

   keyslot_usage #(
      .NUM_SLOTS (NUM_SLOTS),
      .USE_LIMIT (USE_LIMIT),
      .CNT_W     (CNT_W)
   ) u_usage (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (wr_onehot),
      .inc        (inc_onehot),
      .exp_en     (slot_exp_en),
      .expire_evt (expire_evt)
   );

   keyslot_ctx #(
      .NUM_SLOTS    (NUM_SLOTS),
      .ID_W         (ID_W),
      .KEY_W        (KEY_W),
      .NONCE_W      (NONCE_W),
      .AAD_W        (AAD_W),
      .PLEN_W       (PLEN_W),
      .KEY_SNAPSHOT (KEY_SNAPSHOT)
   ) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_valid   (ld_valid),
      .ld_id      (ld_key_id),
      .ld_nonce   (ld_nonce),
      .ld_dir     (ld_dir),
      .ld_aad     (ld_aad_len),
      .ld_plen    (ld_pay_len),
      .slot_valid (slot_valid),
      .key_of_ctx (key_of_ctx),
      .key_of_ld  (key_of_ld),
      .ctx_id     (ctx_id),
      .ctx_live   (ctx_live),
      .start_o    (cph_start),
      .err_o      (ld_err),
      .key_o      (cph_key),
      .nonce_o    (cph_nonce),
      .dir_o      (cph_dir),
      .aad_o      (cph_aad_len),
      .plen_o     (cph_pay_len)
   );

   assign cph_ctx_bad = ctx_live && !slot_valid[ctx_id];

endmodule

// File: rtl/keyslot_cache_chk.sv
module keyslot_cache_chk #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned ID_W      = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 kw_en,
   input logic [ID_W-1:0]      kw_id,
   input logic                 ld_valid,
   input logic                 ld_err,
   input logic                 cph_start,
   input logic                 frame_done,
   input logic [NUM_SLOTS-1:0] renego_req
);

   // R4: a refused load never also starts the cipher
   a_r4_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      ld_err |-> !cph_start);

   // R3: a start pulse only follows a load
   a_r3_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      cph_start |-> $past(ld_valid));

   // R3: start lasts a single cycle unless a second load followed
   a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      (cph_start && !$past(ld_valid, 1) ) |-> 1'b0);

   // R2: a key write clears the slot's request at the next edge
   a_r2_write_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
      kw_en |=> !renego_req[$past(kw_id)]);

   // R4: a refused load only follows a load
   a_r4_err_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_err |-> $past(ld_valid));

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
      // R6: a request only rises after a finished frame
      a_r6_req_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(renego_req[g]) |-> $past(frame_done));
      // R11: a request never rises right after a write to that slot
      a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (kw_en && kw_id == ID_W'(g)) |=> !renego_req[g]);
   end

endmodule

bind keyslot_cache keyslot_cache_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ID_W      (ID_W)
) u_chk (.*);

// File: tb/keyslot_cache_tb_top.sv
`timescale 1ns/1ps
module keyslot_cache_tb_top;

   localparam int NS    = 4;
   localparam int LIMIT = 255;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         kw_en = 1'b0;
   logic [1:0]   kw_id = '0;
   logic [127:0] kw_key = '0;
   logic         kw_expire_en = 1'b0;
   logic         ld_valid = 1'b0;
   logic [1:0]   ld_key_id = '0;
   logic [63:0]  ld_nonce = '0;
   logic         ld_dir = 1'b0;
   logic [15:0]  ld_aad_len = '0;
   logic [15:0]  ld_pay_len = '0;
   logic         frame_done = 1'b0;
   logic         ld_err, cph_start, cph_dir, cph_ctx_bad;
   logic [127:0] cph_key;
   logic [63:0]  cph_nonce;
   logic [15:0]  cph_aad_len, cph_pay_len;
   logic [NS-1:0] renego_req;

   always #4 clk = ~clk;

   keyslot_cache dut_i (
      .clk(clk), .rst_n(rst_n),
      .kw_en(kw_en), .kw_id(kw_id), .kw_key(kw_key), .kw_expire_en(kw_expire_en),
      .ld_valid(ld_valid), .ld_key_id(ld_key_id), .ld_nonce(ld_nonce), .ld_dir(ld_dir),
      .ld_aad_len(ld_aad_len), .ld_pay_len(ld_pay_len),
      .ld_err(ld_err), .cph_start(cph_start), .cph_key(cph_key), .cph_nonce(cph_nonce),
      .cph_dir(cph_dir), .cph_aad_len(cph_aad_len), .cph_pay_len(cph_pay_len),
      .cph_ctx_bad(cph_ctx_bad), .frame_done(frame_done), .renego_req(renego_req)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference model
   bit          m_valid [NS];
   bit          m_en    [NS];
   bit          m_req   [NS];
   int          m_cnt   [NS];
   logic [127:0] m_key  [NS];
   bit          m_start, m_err, m_live, m_dir;
   int          m_id;
   logic [63:0] m_nonce;
   logic [15:0] m_aad, m_plen;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_valid[i] = 0; m_en[i] = 0; m_req[i] = 0; m_cnt[i] = 0; m_key[i] = '0;
         end
         m_start = 0; m_err = 0; m_live = 0; m_dir = 0; m_id = 0;
         m_nonce = '0; m_aad = '0; m_plen = '0;
      end else begin
         bit acc;
         int old_id;
         bit old_valid [NS];
         old_id = m_id;
         for (int i = 0; i < NS; i++) old_valid[i] = m_valid[i];
         acc = ld_valid && old_valid[ld_key_id];
         // frame accounting against the context held before this edge
         if (frame_done && m_live && old_valid[old_id] && !(kw_en && kw_id == old_id)) begin
            if (m_cnt[old_id] < LIMIT) m_cnt[old_id]++;
            if (m_en[old_id] && m_cnt[old_id] == LIMIT) begin
               m_valid[old_id] = 0; m_req[old_id] = 1;
            end
         end
         if (kw_en) begin
            m_valid[kw_id] = 1; m_en[kw_id] = kw_expire_en; m_req[kw_id] = 0;
            m_cnt[kw_id] = 0; m_key[kw_id] = kw_key;
         end
         m_start = acc;
         m_err   = ld_valid && !acc;
         if (acc) begin
            m_live = 1; m_id = ld_key_id; m_nonce = ld_nonce; m_dir = ld_dir;
            m_aad = ld_aad_len; m_plen = ld_pay_len;
         end
      end
   end

   // Compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NS-1:0] er;
         for (int i = 0; i < NS; i++) er[i] = m_req[i];
         chk(cph_start == m_start, "R3", "cph_start", 128'(cph_start), 128'(m_start));
         chk(ld_err == m_err, "R4", "ld_err", 128'(ld_err), 128'(m_err));
         chk(renego_req == er, "R6", "renego_req", 128'(renego_req), 128'(er));
         chk(cph_ctx_bad == (m_live && !m_valid[m_id]), "R7", "cph_ctx_bad",
             128'(cph_ctx_bad), 128'(m_live && !m_valid[m_id]));
         chk(cph_key == m_key[m_id], "R3", "cph_key", cph_key, m_key[m_id]);
         chk(cph_nonce == m_nonce, "R3", "cph_nonce", 128'(cph_nonce), 128'(m_nonce));
         chk(cph_dir == m_dir, "R3", "cph_dir", 128'(cph_dir), 128'(m_dir));
         chk(cph_aad_len == m_aad, "R3", "cph_aad_len", 128'(cph_aad_len), 128'(m_aad));
         chk(cph_pay_len == m_plen, "R3", "cph_pay_len", 128'(cph_pay_len), 128'(m_plen));
      end
   end

   task automatic step();
      @(posedge clk); #2;
      kw_en = 0; ld_valid = 0; frame_done = 0;
   endtask

   task automatic wr(input int id, input logic [127:0] k, input bit en);
      kw_en = 1; kw_id = 2'(id); kw_key = k; kw_expire_en = en; step();
   endtask

   task automatic ld(input int id, input logic [63:0] n, input bit d,
                     input logic [15:0] a, input logic [15:0] p);
      ld_valid = 1; ld_key_id = 2'(id); ld_nonce = n; ld_dir = d;
      ld_aad_len = a; ld_pay_len = p; step();
   endtask

   task automatic frames(input int n);
      for (int i = 0; i < n; i++) begin frame_done = 1; step(); end
   endtask

   task automatic sample();
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      sample();
      // R1: reset state
      chk(renego_req == '0 && !cph_start && !ld_err && !cph_ctx_bad && cph_key == '0,
          "R1", "reset outputs", 128'({renego_req, cph_start, ld_err, cph_ctx_bad}), 128'(0));
      #1;
      // R10: frame with no context held
      frames(3);
      // R4: load of a never-written slot
      ld(3, 64'h11, 0, 16'd5, 16'd7);
      sample(); chk(ld_err && !cph_start, "R4", "invalid load", 128'({ld_err, cph_start}), 128'b10);
      #1;
      // R2: write keys
      wr(0, 128'hA0A0_0000_1111_2222_3333_4444_5555_6666, 1);
      wr(1, 128'hB1B1_7777_8888_9999_AAAA_BBBB_CCCC_DDDD, 0);
      wr(2, 128'hC2C2_0123_4567_89AB_CDEF_0011_2233_4455, 1);
      // R3: accepted loads and context switch without key reload
      ld(0, 64'h0102_0304_0506_0708, 0, 16'd13, 16'd50);
      sample(); chk(cph_start && cph_key[127:112] == 16'hA0A0 && !cph_dir,
                    "R3", "load slot0", 128'({cph_start, cph_key[127:112]}), 128'h1A0A0);
      #1;
      ld(1, 64'hFFEE_DDCC_BBAA_9988, 1, 16'd0, 16'd127);
      sample(); chk(cph_dir && cph_pay_len == 16'd127, "R3", "switch slot1",
                    128'({cph_dir, cph_pay_len}), 128'({1'b1, 16'd127}));
      #1;
      // R5 R6: walk slot0 to one short of the limit, then across it
      ld(0, 64'h5, 0, 16'd2, 16'd20);
      frames(LIMIT - 1);
      sample(); chk(renego_req[0] == 1'b0, "R6", "one short of limit", 128'(renego_req), 128'(0));
      #1;
      frames(1);
      sample(); chk(renego_req[0] && cph_ctx_bad, "R6", "expiry at limit",
                    128'({renego_req[0], cph_ctx_bad}), 128'b11);
      #1;
      // R10: frames against an expired context are ignored
      frames(4);
      // R7: expired slot refused, other slots still served
      ld(0, 64'h6, 0, 16'd1, 16'd1);
      sample(); chk(ld_err, "R7", "load of expired slot", 128'(ld_err), 128'(1)); #1;
      ld(2, 64'h7, 1, 16'd3, 16'd30);
      sample(); chk(cph_start && !cph_ctx_bad, "R7", "other slot accepted",
                    128'({cph_start, cph_ctx_bad}), 128'b10); #1;
      // R8: count-exempt slot survives past the limit
      ld(1, 64'h8, 0, 16'd4, 16'd40);
      frames(LIMIT + 40);
      sample(); chk(!renego_req[1] && !cph_ctx_bad, "R8", "no expiry when exempt",
                    128'({renego_req[1], cph_ctx_bad}), 128'b00); #1;
      // R11: write and counted frame on the same slot in one cycle
      ld(2, 64'h9, 0, 16'd4, 16'd40);
      frames(LIMIT - 1);
      frame_done = 1; kw_en = 1; kw_id = 2'd2;
      kw_key = 128'hC3C3_0000_0000_0000_0000_0000_0000_0001; kw_expire_en = 1; step();
      sample(); chk(!renego_req[2], "R11", "write beats frame", 128'(renego_req), 128'(0)); #1;
      // R11: load in the same cycle as a write to an invalid slot sees old state
      ld_valid = 1; ld_key_id = 2'd0; kw_en = 1; kw_id = 2'd0;
      kw_key = 128'hA1A1_0000_0000_0000_0000_0000_0000_0002; kw_expire_en = 1; step();
      sample(); chk(ld_err && !renego_req[0], "R11", "load sees pre-write state",
                    128'({ld_err, renego_req[0]}), 128'b10); #1;
      // R9: rewritten slot loadable, count restarted
      ld(0, 64'hA, 1, 16'd8, 16'd9);
      sample(); chk(cph_start && cph_key[127:112] == 16'hA1A1, "R9", "rewritten slot",
                    128'({cph_start, cph_key[127:112]}), 128'h1A1A1); #1;
      ld(2, 64'hB, 0, 16'd1, 16'd2);
      frames(LIMIT - 1);
      sample(); chk(!renego_req[2], "R9", "count restarted", 128'(renego_req[2]), 128'(0)); #1;
      frames(1);
      sample(); chk(renego_req[2], "R9", "expires after new full limit",
                    128'(renego_req[2]), 128'(1)); #1;
      // Mixed traffic, checked cycle by cycle against the model
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 15);
         if (r == 0) begin
            kw_en = 1; kw_id = 2'($urandom_range(0, 3)); kw_key = {$urandom, $urandom, $urandom, $urandom};
            kw_expire_en = 1'($urandom_range(0, 1));
         end
         if (r >= 1 && r <= 3) begin
            ld_valid = 1; ld_key_id = 2'($urandom_range(0, 3)); ld_nonce = {$urandom, $urandom};
            ld_dir = 1'($urandom_range(0, 1)); ld_aad_len = 16'($urandom); ld_pay_len = 16'($urandom);
         end
         frame_done = (r >= 4);
         step();
      end
      repeat (2) step();
      sample();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule